// File: doc/BRIEF.md
# Row Bank Hit-String Finder

This block takes one row of binary pixel decisions for a 64-column bank and turns it into a short list of hit strings. A string is a run of neighbouring columns that are all hit. Each string becomes a state: the column where the run starts, plus a length code for one to four pixels. A run longer than four pixels is cut into back-to-back states of four, and the remainder forms the last state. A lone noisy pixel becomes an ordinary one-pixel state.

A pulse on `row_start` loads a new row while the block is idle. The block then emits one state per clock on a valid/ready stream, lowest column first. It keeps no more than six states per row. When more strings remain after the sixth state, it ends the row and raises an overflow flag. The end of each row is marked by a single-cycle `row_done`. With the stream never stalled, a full row completes within seven cycles of the load, which fits a fixed per-row cycle budget. Several instances, one per bank, run side by side. Joining strings across bank edges is left to the logic downstream.

Top module: `hit_string_finder`

## Requirements
- R1: After reset, with no row loaded, `st_valid`, `row_done` and `row_overflow` are all 0.
- R2: Each state gives `st_col` as the lowest column of a run of hit pixels, with bit i of `row_hits` standing for column i. It gives `st_len` as the pixel count minus one: 00 means 1 pixel and 11 means 4 pixels. States of a row come out in increasing column order.
- R3: A run longer than 4 pixels is emitted as successive states of 4 pixels each, followed by one state holding the remainder.
- R4: A hit pixel with no hit neighbour is emitted as a state with `st_len` = 00.
- R5: At most 6 states are emitted per row. If a hit pixel is still unreported after the sixth state is accepted, `row_overflow` is 1 in the `row_done` cycle. Otherwise `row_overflow` stays 0.
- R6: A run that reaches column 63 ends there. No state covers a column past 63.
- R7: `row_done` is high for exactly one cycle per loaded row. That cycle comes after the last state is accepted, or directly after the load cycle when the row has no hits. `st_valid` is 0 in that cycle.
- R8: With `st_ready` held at 1, a row with N emitted states asserts `row_done` in the (N+1)-th cycle after the edge that samples `row_start`. That is no later than the 7th cycle.
- R9: While `st_valid` is 1 and `st_ready` is 0, the offered state stays unchanged in the next cycle.
- R10: A `row_start` pulse that arrives while a row is still being processed, up to and including its `row_done` cycle, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| row_start | input | 1 | Load `row_hits` as a new row (idle only) |
| row_hits | input | 64 | Discriminator outputs of the row, bit i is column i |
| st_valid | output | 1 | A state is offered |
| st_ready | input | 1 | Downstream accepts the offered state |
| st_col | output | 6 | Starting column of the offered state |
| st_len | output | 2 | Length code, pixels minus one |
| row_done | output | 1 | One-cycle end-of-row marker |
| row_overflow | output | 1 | Strings were dropped in this row (valid with `row_done`) |

## Verification
The finder is driven with random rows of three densities. Sparse rows mainly hold single pixels and so exercise the one-pixel code. Medium rows mix short runs. Dense rows hold long runs and often overflow, which separates run splitting from the six-state limit. Directed rows cover the cases the random mix reaches only by chance: an empty row, all columns hit, alternating columns, exactly six singles, and runs of five, four and one that touch column 63. Each row is run either with `st_ready` held high, to test the cycle count to `row_done`, or with random stalls, to test that a held state does not change. A second `row_start` carrying the inverted row is injected during processing, and any state taken from it would show up as a mismatch.

// File: rtl/hsf_pkg.sv
// Shared constants for the hit-string finder.
// Assumes one bank of 64 columns; widths derive from these values.
package hsf_pkg;
    localparam int BANK_COLS   = 64;
    localparam int RUN_MAX     = 4;
    localparam int STATE_LIMIT = 6;
    localparam int COL_W       = $clog2(BANK_COLS);
    localparam int LEN_W       = $clog2(RUN_MAX);
endpackage

// File: rtl/hsf_lead_find.sv
// Lowest-set-bit finder: returns the index of the lowest hit column.
// Two levels: each group of GRP bits finds its own lowest bit, and the
// lowest non-empty group is then chosen. Assumes W is a multiple of GRP.
module hsf_lead_find #(
    parameter int W   = 64,
    parameter int GRP = 8,
    localparam int IW = $clog2(W),
    localparam int GW = $clog2(GRP),
    localparam int NG = W / GRP
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    logic [NG-1:0] grp_any;
    logic [GW-1:0] grp_idx [NG];

    for (genvar g = 0; g < NG; g++) begin : g_grp
        // Purpose: lowest set bit inside one group.
        always_comb begin
            grp_any[g] = 1'b0;
            grp_idx[g] = '0;
            for (int b = GRP - 1; b >= 0; b--) begin
                if (vec[g*GRP + b]) begin
                    grp_any[g] = 1'b1;
                    grp_idx[g] = GW'(b);
                end
            end
        end
    end

    // Purpose: pick the lowest group holding a hit and build the full index.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int g = NG - 1; g >= 0; g--) begin
            if (grp_any[g]) begin
                found = 1'b1;
                idx   = IW'(g * GRP) + IW'(grp_idx[g]);
            end
        end
    end
endmodule

// File: rtl/hsf_run_len.sv
// Run measurer: from the lead hit at idx, counts contiguous hits up to
// MAXR, returns the length code (pixels - 1) and a clear mask over them.
// Shifting down fills with zeros, so a run stops at the top bank column.
module hsf_run_len #(
    parameter int W    = 64,
    parameter int MAXR = 4,
    localparam int IW  = $clog2(W),
    localparam int LW  = $clog2(MAXR)
) (
    input  logic [W-1:0]  vec,
    input  logic [IW-1:0] idx,
    output logic [LW-1:0] len_code,
    output logic [W-1:0]  clr_mask
);
    logic [W-1:0] shifted;
    logic [W-1:0] run_lo;
    logic         cont;

    assign shifted = vec >> idx;

    // Purpose: measure the run length from the lead bit, capped at MAXR.
    always_comb begin
        run_lo   = '0;
        len_code = '0;
        cont     = 1'b1;
        for (int k = 0; k < MAXR; k++) begin
            if (cont && shifted[k]) begin
                run_lo[k] = 1'b1;
                len_code  = LW'(k);
            end else begin
                cont = 1'b0;
            end
        end
    end

    assign clr_mask = run_lo << idx;
endmodule

// File: rtl/hit_string_finder.sv
// Row bank hit-string finder top.
// Loads a row when idle, offers one state per cycle (lowest column
// first), clears each accepted run from the pending vector, and ends the
// row when no hit remains or the state limit is reached. Overflow is
// reported with row_done. row_start is ignored while a row is busy.
module hit_string_finder
    import hsf_pkg::*;
#(
    parameter int COLS       = BANK_COLS,
    parameter int MAX_LEN    = RUN_MAX,
    parameter int MAX_STATES = STATE_LIMIT,
    localparam int CW  = $clog2(COLS),
    localparam int LW  = $clog2(MAX_LEN),
    localparam int NW  = $clog2(MAX_STATES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            row_start,
    input  logic [COLS-1:0] row_hits,
    output logic            st_valid,
    input  logic            st_ready,
    output logic [CW-1:0]   st_col,
    output logic [LW-1:0]   st_len,
    output logic            row_done,
    output logic            row_overflow
);
    logic [COLS-1:0] pend_q;
    logic            busy_q;
    logic [NW-1:0]   sent_q;
    logic            hit_left;
    logic [CW-1:0]   lead_idx;
    logic [LW-1:0]   run_code;
    logic [COLS-1:0] run_mask;
    logic            at_limit;
    logic            fire;
    logic            finish;

    hsf_lead_find #(.W(COLS), .GRP(8)) u_lead (
        .vec   (pend_q),
        .found (hit_left),
        .idx   (lead_idx)
    );

    hsf_run_len #(.W(COLS), .MAXR(MAX_LEN)) u_run (
        .vec      (pend_q),
        .idx      (lead_idx),
        .len_code (run_code),
        .clr_mask (run_mask)
    );

    // Purpose: decode offer, acceptance and end-of-row conditions.
    always_comb begin
        at_limit = (sent_q == NW'(MAX_STATES));
        st_valid = busy_q && hit_left && !at_limit;
        fire     = st_valid && st_ready;
        finish   = busy_q && (!hit_left || at_limit);
    end

    assign st_col       = lead_idx;
    assign st_len       = run_code;
    assign row_done     = finish;
    assign row_overflow = finish && hit_left;

    // Purpose: row load, run clearing, state counting and busy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            pend_q <= '0;
            sent_q <= '0;
        end else if (!busy_q) begin
            if (row_start) begin
                pend_q <= row_hits;
                busy_q <= 1'b1;
                sent_q <= '0;
            end
        end else if (finish) begin
            busy_q <= 1'b0;
        end else if (fire) begin
            pend_q <= pend_q & ~run_mask;
            sent_q <= sent_q + 1'b1;
        end
    end
endmodule

// File: rtl/hsf_checker.sv
// Protocol checker for hit_string_finder, attached with bind below.
// Counts accepted states from the ports to relate them to row_done.
module hsf_checker #(
    parameter int COLS       = 64,
    parameter int MAX_LEN    = 4,
    parameter int MAX_STATES = 6,
    localparam int CW = $clog2(COLS),
    localparam int LW = $clog2(MAX_LEN)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_valid,
    input logic          st_ready,
    input logic [CW-1:0] st_col,
    input logic [LW-1:0] st_len,
    input logic          row_done,
    input logic          row_overflow
);
    int acc_cnt;

    // Purpose: count accepted states within the current row.
    always_ff @(posedge clk) begin
        if (!rst_n || row_done) acc_cnt <= 0;
        else if (st_valid && st_ready) acc_cnt <= acc_cnt + 1;
    end

    AST_STATE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> acc_cnt < MAX_STATES); // R5
    AST_OVF_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        row_overflow |-> (row_done && acc_cnt == MAX_STATES)); // R5
    AST_DONE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        row_done |-> !st_valid); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        row_done |=> !row_done); // R7
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready) |=> (st_valid && $stable(st_col) && $stable(st_len))); // R9
    AST_IN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> (int'(st_col) + int'(st_len) < COLS)); // R6
endmodule

bind hit_string_finder hsf_checker #(
    .COLS(COLS), .MAX_LEN(MAX_LEN), .MAX_STATES(MAX_STATES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_col(st_col), .st_len(st_len), .row_done(row_done),
    .row_overflow(row_overflow)
);

// File: tb/hit_string_finder_tb.sv
// Bench for hit_string_finder: directed and seeded random rows, each
// compared with a bench model of the string encoding.
module hit_string_finder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        row_start = 1'b0;
    logic [63:0] row_hits = '0;
    logic        st_valid;
    logic        st_ready = 1'b1;
    logic [5:0]  st_col;
    logic [1:0]  st_len;
    logic        row_done;
    logic        row_overflow;

    int n_chk = 0;
    int n_bad = 0;

    int exp_col [6];
    int exp_len [6];
    int exp_n;
    bit exp_ovf;

    always #5 clk = ~clk;

    hit_string_finder u_dut (
        .clk(clk), .rst_n(rst_n), .row_start(row_start), .row_hits(row_hits),
        .st_valid(st_valid), .st_ready(st_ready), .st_col(st_col),
        .st_len(st_len), .row_done(row_done), .row_overflow(row_overflow)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Model: scan low to high, runs capped at 4, six kept, rest flagged.
    task automatic model(input logic [63:0] v);
        int i;
        int len;
        exp_n = 0;
        exp_ovf = 0;
        i = 0;
        while (i < 64) begin
            if (v[i]) begin
                len = 1;
                while (len < 4 && i + len < 64 && v[i + len]) len++;
                if (exp_n < 6) begin
                    exp_col[exp_n] = i;
                    exp_len[exp_n] = len - 1;
                    exp_n++;
                end else begin
                    exp_ovf = 1;
                end
                i = i + len;
            end else begin
                i++;
            end
        end
    endtask

    // Runs one row; stall selects random ready, inject tries a second load.
    task automatic run_row(input logic [63:0] v, input bit stall, input bit inject);
        int got;
        int cyc;
        bit done;
        bit held;
        int h_col;
        int h_len;
        model(v);
        @(negedge clk);
        row_hits  = v;
        row_start = 1'b1;
        @(negedge clk);
        row_start = 1'b0;
        got  = 0;
        done = 0;
        held = 0;
        h_col = 0;
        h_len = 0;
        for (cyc = 1; cyc <= 200 && !done; cyc++) begin
            if (cyc > 1) @(negedge clk);
            row_start = (inject && cyc == 1);
            if (inject && cyc == 1) row_hits = ~v;
            if (inject && cyc == 2) row_hits = v;
            st_ready = stall ? 1'($urandom_range(0, 1)) : 1'b1;
            #1;
            if (held) begin
                check(st_valid && int'(st_col) == h_col && int'(st_len) == h_len,
                      "R9", int'(st_col), h_col);
                held = 0;
            end
            if (st_valid && st_ready) begin
                if (got < exp_n) begin
                    check(int'(st_col) == exp_col[got], "R2 col", int'(st_col), exp_col[got]);
                    check(int'(st_len) == exp_len[got], "R2/R3/R4/R6 len", int'(st_len), exp_len[got]);
                end else begin
                    check(1'b0, "R5 extra state", got + 1, exp_n);
                end
                got++;
            end else if (st_valid) begin
                held  = 1;
                h_col = int'(st_col);
                h_len = int'(st_len);
            end
            if (row_done) begin
                done = 1;
                check(!st_valid, "R7 valid in done", int'(st_valid), 0);
                check(got == exp_n, inject ? "R10 state count" : "R5 state count", got, exp_n);
                check(row_overflow == exp_ovf, "R5 overflow", int'(row_overflow), int'(exp_ovf));
                if (!stall) check(cyc == exp_n + 1, "R8 done cycle", cyc, exp_n + 1);
            end
        end
        row_start = 1'b0;
        check(done, "R7 row_done seen", int'(done), 1);
        @(negedge clk);
        #1;
        check(!row_done && !st_valid, "R7 single pulse", int'(row_done), 0);
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] r;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!st_valid && !row_done && !row_overflow, "R1 reset", int'(st_valid), 0);

        run_row(64'h0, 1'b0, 1'b0);                     // R7 empty row
        run_row('1, 1'b0, 1'b0);                        // R3 R5 all hit
        run_row(64'h5555_5555_5555_5555, 1'b0, 1'b0);   // R4 R5 singles overflow
        run_row(64'h0000_0000_0000_0555, 1'b0, 1'b0);   // R4 R5 exactly six
        run_row(64'h0000_0000_0000_1555, 1'b0, 1'b0);   // R5 seventh dropped
        run_row(64'h8000_0000_0000_0000, 1'b0, 1'b0);   // R6 bit 63 alone
        run_row(64'hF000_0000_0000_0000, 1'b0, 1'b0);   // R6 four at top
        run_row(64'hF800_0000_0000_0000, 1'b0, 1'b0);   // R3 R6 five at top
        run_row(64'h0000_0000_0000_001F, 1'b0, 1'b0);   // R3 five at bottom
        run_row(64'h0000_0000_00FF_0000, 1'b1, 1'b0);   // R3 R9 eight with stalls
        run_row(64'h8000_0000_0000_0001, 1'b0, 1'b1);   // R10 injected load

        for (int n = 0; n < 300; n++) begin
            case (n % 3)
                0: r = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
                1: r = {$urandom, $urandom} & {$urandom, $urandom};
                default: r = {$urandom, $urandom} | {$urandom, $urandom};
            endcase
            run_row(r, 1'($urandom_range(0, 1)), (n % 7) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule